// File: doc/BRIEF.md
# Clock-Event State Sequencer with Delays

This block steps through a small programmable table as decoded clock events arrive, and it issues a one-cycle test trigger when the last step is satisfied. The events come from two streams: a primary timing-clock stream and a beam-synchronous stream. Each event has an 8-bit code and a stream-select bit. A step can be satisfied by its event alone, or by its event followed by a delay that is timed on one of four shared 16-bit timers. The timers count a 100 µs timebase tick.

Entry 0 of the table is the restart (escape) step. Its event starts the sequence at entry 1, or restarts it from any point, and it stops every timer. Its low bits give how many entries follow it. The table is loaded and read back through a sequential access port that acknowledges or refuses each access one cycle later. A global reset event returns the sequence to entry 0 and stops the timers. This event is either the dedicated input or code 8'hA8 on the primary stream.

Top module: `evt_seq`

## Requirements
- R1: During and after reset, `trig`, `active`, `acc_ack` and `acc_nak` are low.
- R2: An entry word is {code[15:8], stream[7], delay select[6:4], trigger flag[3], count[2:0]}. A write at position 0 is accepted only if the delay select is 7, the trigger flag is 0 and the count is 1 to 7. Otherwise it is refused with `acc_nak` and the position does not advance.
- R3: A write at positions 1 to 7 is refused when the delay select is 4, 5 or 6.
- R4: Accesses are sequential from position 0 after `ctx_clr`, and each accepted read or write advances one position. `acc_ack` or `acc_nak` pulses one cycle after the request, and `rdata` carries the entry on that cycle. A ninth write or a ninth read is refused.
- R5: The sequence runs only once entries 0 through count have been written. An event that matches entry 0's code and stream then sets `active` on the next cycle.
- R6: At entry k ≥ 1 with delay select 7, the matching event satisfies the entry at once. The sequence moves to entry k+1.
- R7: At entry k ≥ 1 with delay select 0 to 3, the matching event loads that timer from its programmed value D. The entry is satisfied on the cycle after the clock edge that carries the D-th tick.
- R8: While a timer runs for the current entry, every event other than the escape event and the global reset is ignored. At any entry, an event that does not match the current entry is ignored.
- R9: The escape event at any entry restarts the sequence at entry 1 and stops all timers.
- R10: `grst`, or code 8'hA8 on the primary stream (stream bit 0), returns the sequence to entry 0, clears `active` and stops all timers. It takes priority over the escape event.
- R11: When the satisfied entry has trigger flag 1, or is entry number count, `trig` pulses for one cycle and `active` clears in the same cycle. The sequence then waits at entry 0 for the escape event.
- R12: `dly_we` stores `dly_val` into timer register `dly_sel`. A running timer keeps the value it was loaded with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Decoded event strobe |
| ev_code | input | 8 | Event code |
| ev_beam | input | 1 | Stream select: 0 primary, 1 beam-synchronous |
| tick | input | 1 | Timebase tick, one per 100 µs |
| grst | input | 1 | Global reset event |
| ctx_clr | input | 1 | Return the access position to 0 |
| tw_en | input | 1 | Table write request |
| tr_en | input | 1 | Table read request |
| wdata | input | 16 | Table write data |
| dly_we | input | 1 | Timer register write |
| dly_sel | input | 2 | Timer register select |
| dly_val | input | DLY_W | Timer value in ticks |
| rdata | output | 16 | Table read data |
| acc_ack | output | 1 | Access accepted |
| acc_nak | output | 1 | Access refused |
| trig | output | 1 | Test trigger pulse |
| active | output | 1 | Sequence is past entry 0 |

## Verification
All results are registered, so the bench drives inputs 1 ns after a rising edge and samples 1 ns after the next edge.

- Acknowledges, refusals, read data, `active`, and triggers from no-delay entries are all due exactly one edge after the request or event.
- A delayed trigger is due one edge after the edge that carries the D-th tick. The bench therefore checks that `trig` is still low right after the last tick and high one cycle later.
- Any extra or missing register stage, and any reload of a running timer by an event that should be ignored, shifts the result onto a cycle where the bench expects the other value.

// File: rtl/evt_seq.sv
module evt_seq #(
  parameter int DLY_W = 16,
  parameter logic [7:0] GRST_CODE = 8'hA8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [7:0]       ev_code,
  input  logic             ev_beam,
  input  logic             tick,
  input  logic             grst,
  input  logic             ctx_clr,
  input  logic             tw_en,
  input  logic             tr_en,
  input  logic [15:0]      wdata,
  input  logic             dly_we,
  input  logic [1:0]       dly_sel,
  input  logic [DLY_W-1:0] dly_val,
  output logic [15:0]      rdata,
  output logic             acc_ack,
  output logic             acc_nak,
  output logic             trig,
  output logic             active
);
  localparam int NENT = 8;
  localparam int NTMR = 4;

  logic [15:0]      tbl [NENT];
  logic [DLY_W-1:0] dly [NTMR];
  logic [3:0]       ptr, wcnt;
  logic [2:0]       idx;
  logic [NTMR-1:0]  run, zro;

  wire [2:0] nsub   = tbl[0][2:0];
  wire       tbl_ok = wcnt > {1'b0, nsub};
  wire       ev_grst = grst | (ev_valid & ~ev_beam & (ev_code == GRST_CODE));
  wire       ev_esc = ev_valid & (ev_code == tbl[0][15:8]) & (ev_beam == tbl[0][7]);
  wire       ev_cur = ev_valid & (ev_code == tbl[idx][15:8]) & (ev_beam == tbl[idx][7]);
  wire [2:0] csel   = tbl[idx][6:4];
  wire       busy   = |run;
  wire       expired = |(run & zro);
  wire       in_seq = idx != 3'd0;
  wire       sat    = in_seq & (expired | (~busy & ev_cur & (csel == 3'd7)));
  wire       start  = in_seq & ~busy & ev_cur & (csel != 3'd7);
  wire       fire   = sat & (tbl[idx][3] | (idx == nsub));
  wire       stop   = ev_grst | ~tbl_ok | ev_esc;

  wire first_ok = (wdata[6:4] == 3'd7) & ~wdata[3] & (wdata[2:0] != 3'd0);
  wire later_ok = ~wdata[6] | (wdata[5:4] == 2'b11);
  wire in_rng   = ptr < 4'd8;
  wire wok      = in_rng & ((ptr == 4'd0) ? first_ok : later_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      wcnt <= '0;
      rdata <= '0;
      acc_ack <= 1'b0;
      acc_nak <= 1'b0;
      for (int i = 0; i < NENT; i++) tbl[i] <= '0;
      for (int i = 0; i < NTMR; i++) dly[i] <= '0;
    end else begin
      acc_ack <= 1'b0;
      acc_nak <= 1'b0;
      if (ctx_clr) begin
        ptr <= '0;
      end else if (tw_en) begin
        if (wok) begin
          tbl[ptr[2:0]] <= wdata;
          ptr <= ptr + 4'd1;
          wcnt <= ptr + 4'd1;
          acc_ack <= 1'b1;
        end else begin
          acc_nak <= 1'b1;
        end
      end else if (tr_en) begin
        if (in_rng) begin
          rdata <= tbl[ptr[2:0]];
          ptr <= ptr + 4'd1;
          acc_ack <= 1'b1;
        end else begin
          acc_nak <= 1'b1;
        end
      end
      if (dly_we) dly[dly_sel] <= dly_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      active <= 1'b0;
      trig <= 1'b0;
    end else begin
      trig <= 1'b0;
      if (ev_grst || !tbl_ok) begin
        idx <= '0;
        active <= 1'b0;
      end else if (ev_esc) begin
        idx <= 3'd1;
        active <= 1'b1;
      end else if (fire) begin
        idx <= '0;
        active <= 1'b0;
        trig <= 1'b1;
      end else if (sat) begin
        idx <= idx + 3'd1;
      end
    end
  end

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    logic             run_q;
    logic [DLY_W-1:0] cnt_q;
    assign run[g] = run_q;
    assign zro[g] = cnt_q == '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (stop || (run_q && cnt_q == '0)) begin
        run_q <= 1'b0;
      end else if (start && csel == 3'(g)) begin
        run_q <= 1'b1;
        cnt_q <= dly[g];
      end else if (run_q && tick && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_seq_chk.sv
module evt_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trig,
  input logic       active,
  input logic       acc_ack,
  input logic       acc_nak,
  input logic       tw_en,
  input logic       tr_en,
  input logic       grst,
  input logic       ev_esc,
  input logic       tbl_ok,
  input logic [2:0] idx,
  input logic [3:0] run
);
  // R11
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) trig |=> !trig);
  // R11
  trig_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) trig |-> !active && idx == 3'd0);
  // R10
  grst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) grst |=> !active && run == 4'd0 && idx == 3'd0);
  // R9
  esc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_esc && tbl_ok && !grst) |=> active && idx == 3'd1 && run == 4'd0);
  // R4
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(acc_ack && acc_nak));
  // R4
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) (acc_ack || acc_nak) |-> $past(tw_en || tr_en));
  // R7
  one_tmr_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(run));
endmodule

bind evt_seq evt_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .active(active),
  .acc_ack(acc_ack), .acc_nak(acc_nak), .tw_en(tw_en), .tr_en(tr_en),
  .grst(grst), .ev_esc(ev_esc), .tbl_ok(tbl_ok), .idx(idx), .run(run)
);

// File: tb/evt_seq_tb.sv
module evt_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 0, ev_beam = 0, tick = 0, grst = 0, ctx_clr = 0, tw_en = 0, tr_en = 0, dly_we = 0;
  logic [7:0] ev_code = 0;
  logic [15:0] wdata = 0;
  logic [1:0] dly_sel = 0;
  logic [15:0] dly_val = 0;
  logic [15:0] rdata;
  logic acc_ack, acc_nak, trig, active;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code), .ev_beam(ev_beam),
    .tick(tick), .grst(grst), .ctx_clr(ctx_clr), .tw_en(tw_en), .tr_en(tr_en),
    .wdata(wdata), .dly_we(dly_we), .dly_sel(dly_sel), .dly_val(dly_val),
    .rdata(rdata), .acc_ack(acc_ack), .acc_nak(acc_nak), .trig(trig), .active(active)
  );

  // {expected ack, write data}
  localparam logic [16:0] VEC [13] = '{
    17'h0107A, 17'h01032, 17'h01070, 17'h11072, 17'h020D0, 17'h120F0, 17'h13028,
    17'h16370, 17'h16470, 17'h16570, 17'h16670, 17'h16770, 17'h06870
  };
  logic [15:0] expt [8];
  int nacc = 0;

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d); tw_en = 1; wdata = d; cyc(); tw_en = 0; endtask
  task automatic rd(); tr_en = 1; cyc(); tr_en = 0; endtask
  task automatic ctx(); ctx_clr = 1; cyc(); ctx_clr = 0; endtask
  task automatic ev(input logic [7:0] c, input logic b);
    ev_valid = 1; ev_code = c; ev_beam = b; cyc(); ev_valid = 0;
  endtask
  task automatic ticks(input int n); tick = 1; repeat (n) cyc(); tick = 0; endtask
  task automatic setdly(input logic [1:0] ch, input logic [15:0] v);
    dly_we = 1; dly_sel = ch; dly_val = v; cyc(); dly_we = 0;
  endtask

  initial begin
    repeat (3) cyc();
    chk("R1 trig in reset", trig, 0);
    rst_n = 1;
    cyc();
    chk("R1 trig", trig, 0);
    chk("R1 active", active, 0);
    chk("R1 ack/nak", {acc_ack, acc_nak}, 0);

    ev(8'h10, 0);
    chk("R5 no table, escape ignored", active, 0);

    ctx();
    for (int i = 0; i < 13; i++) begin
      wr(VEC[i][15:0]);
      chk(i < 3 ? "R2 first entry write" : (i == 4 ? "R3 later entry write" : "R4 write"),
          acc_ack, VEC[i][16]);
      chk("R4 write refusal", acc_nak, !VEC[i][16]);
      if (VEC[i][16]) begin expt[nacc] = VEC[i][15:0]; nacc++; end
    end
    ctx();
    for (int i = 0; i < 8; i++) begin
      rd();
      chk("R4 read ack", acc_ack, 1);
      chk("R4 read data", rdata, expt[i]);
    end
    rd();
    chk("R4 ninth read refused", acc_nak, 1);

    setdly(2'd1, 16'd2);
    setdly(2'd2, 16'd5);

    ev(8'h10, 0);
    chk("R5 escape sets active", active, 1);
    ev(8'h30, 0);
    ev(8'h20, 1);
    chk("R6 no-delay advance, no trigger", trig, 0);
    ev(8'h30, 0);
    ticks(2);
    ev(8'h30, 0);
    ticks(3);
    chk("R7 R8 no trigger on last tick edge", trig, 0);
    cyc();
    chk("R7 delayed trigger", trig, 1);
    chk("R11 active clears with trigger", active, 0);
    cyc();
    chk("R11 trigger is one cycle", trig, 0);
    ev(8'h20, 1);
    chk("R11 waits for escape", active, 0);

    ev(8'h10, 0); ev(8'h20, 1); ev(8'h30, 0);
    ticks(3);
    ev(8'h10, 0);
    chk("R9 escape restarts", active, 1);
    ticks(10); cyc();
    chk("R9 timer stopped by escape", trig, 0);
    ev(8'h20, 1); ev(8'h30, 0);
    ticks(5); cyc();
    chk("R9 sequence runs again", trig, 1);

    ev(8'h10, 0);
    grst = 1; cyc(); grst = 0;
    chk("R10 grst clears active", active, 0);
    ev(8'h10, 0); ev(8'hA8, 1);
    chk("R10 A8 on beam stream no reset", active, 1);
    ev(8'hA8, 0);
    chk("R10 A8 primary resets", active, 0);
    ev(8'h10, 0); ev(8'h20, 1); ev(8'h30, 0);
    grst = 1; cyc(); grst = 0;
    ticks(10); cyc();
    chk("R10 timer stopped by grst", trig, 0);
    grst = 1; ev(8'h10, 0); grst = 0;
    chk("R10 grst beats escape", active, 0);

    ctx();
    wr(16'h11F1);
    chk("R2 new first entry", acc_ack, 1);
    ev(8'h11, 1);
    chk("R5 incomplete table ignored", active, 0);
    wr(16'h2270);
    ev(8'h11, 1);
    chk("R5 beam-stream escape", active, 1);
    ev(8'h22, 0);
    chk("R11 final entry triggers", trig, 1);

    ctx();
    wr(16'h1072); wr(16'h20F0); wr(16'h3018);
    setdly(2'd1, 16'd2);
    ev(8'h10, 0); ev(8'h20, 1); ev(8'h30, 0);
    setdly(2'd1, 16'd9);
    ticks(2);
    chk("R12 loaded value kept", trig, 0);
    cyc();
    chk("R12 timer 1 expiry", trig, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule